// File: doc/BRIEF.md
# Least-Recently-Serviced Port Arbiter

This block decides which of several requesting ports may use a shared single-ported memory in the current memory cycle. Each port raises its ready line when it has an access waiting. In the same cycle the arbiter raises exactly one acknowledge line, for the ready port whose last grant lies furthest in the past. A port that is not acknowledged holds its ready line and stays blocked until its turn comes.

The arbiter keeps a complete recency list of port IDs. Slot 0 holds the least recently served port and the last slot holds the most recently served one. On every grant, the winning ID moves to the last slot, and the IDs that were behind it each shift one slot toward slot 0. The whole list is driven out as a priority vector, so that other shared-resource arbiters, such as lock logic, can apply the same ordering. Each cycle falls into one of two named events. In ARB_IDLE no port is ready, so nothing is acknowledged and the list keeps its order. In ARB_GRANT one port is acknowledged and the list is updated on the clock edge that closes the cycle.

Top module: `lrs_arbiter`

## Requirements
- R1: At most one bit of `ack` is high in any cycle.
- R2: `ack[p]` is high only when `ready[p]` is high in the same cycle.
- R3: When any `ready` bit is high, some `ack` bit is high in the same cycle, because the acknowledge is combinational.
- R4: The acknowledged port is the ready port whose ID sits in the lowest-numbered slot of `prio_order`. Slot k occupies bits [2k+1:2k] for four ports, and slot 0 is the least recently served.
- R5: After reset, slot k of `prio_order` holds port ID k, which gives the value 8'hE4 for four ports.
- R6: On the clock edge after a grant, the granted ID is in the last slot. The IDs that were in lower slots keep their slots. The IDs that were in higher slots each move down one slot, keeping their relative order.
- R7: In a cycle with no ready port, `ack` is all zero and `prio_order` is unchanged on the next edge.
- R8: When exactly one port is ready, it is acknowledged in that cycle, whatever its slot in the order.
- R9: A port whose ready line stays high goes unacknowledged for at most NPORTS-1 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready | input | NPORTS | Per-port access-pending lines |
| ack | output | NPORTS | Per-port grant for the current cycle, one-hot or zero |
| prio_order | output | NPORTS*IDW | Recency list: slot 0 least recent, last slot most recent |

## Verification
The assertions assume that a port which is ready and not acknowledged keeps its ready line high in the next cycle. This is the blocking behaviour that the starvation bound of R9 depends on. The random stimulus does drop ready lines at will, so the waiting counters in the checker clear whenever a port's line falls, and the bound applies only to unbroken waits. Beyond that, the inputs may take any value on any cycle. The directed phases cover the idle cycles, each port alone, and all ports ready together.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
    // Arbitration event for one memory cycle
    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_ev_t;
endpackage

// File: rtl/lrs_pick.sv
module lrs_pick #(
    parameter int NPORTS = 4,
    localparam int IDW = $clog2(NPORTS)
) (
    input  logic [NPORTS-1:0]           ready,
    input  logic [NPORTS-1:0][IDW-1:0]  ord,
    output logic                        found,
    output logic [IDW-1:0]              win_slot,
    output logic [IDW-1:0]              win_id,
    output logic [NPORTS-1:0]           ack
);
    // Scan from the least recent slot upward; first ready port wins
    always_comb begin
        found    = 1'b0;
        win_slot = '0;
        win_id   = '0;
        for (int s = 0; s < NPORTS; s++) begin
            if (!found && ready[ord[s]]) begin
                found    = 1'b1;
                win_slot = IDW'(s);
                win_id   = ord[s];
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_ack
        assign ack[p] = found && (win_id == IDW'(p));
    end
endmodule

// File: rtl/lrs_order.sv
module lrs_order
    import lrs_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int IDW = $clog2(NPORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  arb_ev_t                     ev,
    input  logic [IDW-1:0]              win_slot,
    input  logic [IDW-1:0]              win_id,
    output logic [NPORTS-1:0][IDW-1:0]  ord
);
    for (genvar g = 0; g < NPORTS; g++) begin : g_slot
        if (g == NPORTS - 1) begin : g_last
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ord[g] <= IDW'(g);
                end else begin
                    unique case (ev)
                        ARB_IDLE:  ord[g] <= ord[g];
                        ARB_GRANT: ord[g] <= win_id;
                    endcase
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ord[g] <= IDW'(g);
                end else begin
                    unique case (ev)
                        ARB_IDLE:  ord[g] <= ord[g];
                        ARB_GRANT: if (IDW'(g) >= win_slot) ord[g] <= ord[g+1];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/lrs_arbiter.sv
module lrs_arbiter
    import lrs_pkg::*;
#(
    parameter int NPORTS = 4,
    localparam int IDW = $clog2(NPORTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORTS-1:0]       ready,
    output logic [NPORTS-1:0]       ack,
    output logic [NPORTS*IDW-1:0]   prio_order
);
    logic [NPORTS-1:0][IDW-1:0] ord;
    logic                       found;
    logic [IDW-1:0]             win_slot;
    logic [IDW-1:0]             win_id;
    arb_ev_t                    ev;

    assign ev         = found ? ARB_GRANT : ARB_IDLE;
    assign prio_order = ord;

    lrs_pick #(.NPORTS(NPORTS)) u_pick (
        .ready    (ready),
        .ord      (ord),
        .found    (found),
        .win_slot (win_slot),
        .win_id   (win_id),
        .ack      (ack)
    );

    lrs_order #(.NPORTS(NPORTS)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .win_slot (win_slot),
        .win_id   (win_id),
        .ord      (ord)
    );
endmodule

// File: rtl/lrs_arbiter_chk.sv
module lrs_arbiter_chk #(
    parameter int NPORTS = 4,
    localparam int IDW = $clog2(NPORTS),
    localparam int CW  = IDW + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NPORTS-1:0]       ready,
    input logic [NPORTS-1:0]       ack,
    input logic [NPORTS*IDW-1:0]   prio_order
);
    logic [IDW-1:0] ack_id;
    always_comb begin
        ack_id = '0;
        for (int p = 0; p < NPORTS; p++)
            if (ack[p]) ack_id = IDW'(p);
    end

    logic [NPORTS-1:0][CW-1:0] wait_cnt;
    for (genvar p = 0; p < NPORTS; p++) begin : g_wait
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  wait_cnt[p] <= '0;
            else if (ready[p] && !ack[p]) wait_cnt[p] <= wait_cnt[p] + 1'b1;
            else                         wait_cnt[p] <= '0;
        end
        // R9
        starve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ready[p] && !ack[p]) |-> (wait_cnt[p] < CW'(NPORTS - 1)));
    end

    // R1
    one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
    // R2
    ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack & ~ready) == '0);
    // R3
    work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ready) |-> (|ack));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ready) |=> $stable(prio_order));
    // R6
    mru_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |=> prio_order[NPORTS*IDW-1 -: IDW] == $past(ack_id));
    // R8
    single_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(ready) |-> ack == ready);
endmodule

bind lrs_arbiter lrs_arbiter_chk #(.NPORTS(NPORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .ack        (ack),
    .prio_order (prio_order)
);

// File: tb/sim_lrs_arbiter.sv
module sim_lrs_arbiter;
    localparam int N = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   ready = '0;
    logic [N-1:0]   ack;
    logic [N*IDW-1:0] prio_order;

    int checks = 0;
    int errors = 0;
    int ord_m[N];
    int wait_m[N];
    bit done = 0;

    always #5 clk = ~clk;

    lrs_arbiter #(.NPORTS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ready(ready), .ack(ack), .prio_order(prio_order)
    );

    function automatic logic [N*IDW-1:0] pack_model();
        logic [N*IDW-1:0] v = '0;
        for (int s = 0; s < N; s++) v[s*IDW +: IDW] = IDW'(ord_m[s]);
        return v;
    endfunction

    function automatic int model_winner_slot(logic [N-1:0] r);
        for (int s = 0; s < N; s++) if (r[ord_m[s]]) return s;
        return -1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check, advance model
    task automatic cycle(logic [N-1:0] r);
        int ws;
        logic [N-1:0] exp_ack;
        string tag;
        @(negedge clk);
        ready = r;
        #1;
        ws = model_winner_slot(r);
        exp_ack = (ws < 0) ? '0 : N'(1) << ord_m[ws];
        tag = (r == 0) ? "R7" : ($countones(r) == 1) ? "R8" : "R4";
        check("R6 order", 32'(prio_order), 32'(pack_model()));
        check(tag, 32'(ack), 32'(exp_ack));
        check("R1", 32'($countones(ack) <= 1), 32'd1);
        check("R2", 32'(ack & ~r), 32'd0);
        if (r != 0) check("R3", 32'(ack != 0), 32'd1);
        for (int p = 0; p < N; p++) begin
            if (r[p] && !exp_ack[p]) wait_m[p]++; else wait_m[p] = 0;
            if (wait_m[p] > N - 1) check("R9", 32'(wait_m[p]), 32'(N - 1));
        end
        if (ws >= 0) begin
            int w = ord_m[ws];
            for (int s = ws; s < N - 1; s++) ord_m[s] = ord_m[s+1];
            ord_m[N-1] = w;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < N; s++) begin ord_m[s] = s; wait_m[s] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R5 reset state
        check("R5", 32'(prio_order), 32'h0000_00E4);
        check("R5 ack", 32'(ack), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        // R7 idle cycles keep order
        repeat (3) cycle('0);
        // R8 each port alone, including the most recent one
        cycle(4'b1000);
        cycle(4'b1000);
        cycle(4'b0001);
        cycle(4'b0100);
        cycle(4'b0010);
        // R4 all ready: rotates through recency order
        repeat (8) cycle(4'b1111);
        cycle(4'b0101);
        cycle(4'b1010);
        cycle('0);
        // Random phase
        for (int i = 0; i < 3000; i++) cycle(N'($urandom_range(0, 15)));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule